// File: doc/BRIEF.md
# Hidden IDE Timing Configuration Window

This block sits in front of a legacy IDE host controller's register decode. Normally every access at the controller's base address belongs to the ATA task file, and the block only routes it there. A fixed access pattern on the same addresses opens a hidden configuration window. While the window is open, the same offsets reach a small set of timing registers and not the task file. A dedicated write closes the window again.

Inside the window, software picks a target device through a device-select bit. It writes staged read-cycle and write-cycle timing bytes for that device, and sets a shared address-setup field. It can also read a clock strap that reports the bus clock. Writing a commit code to the control register copies every staged value to the committed timing outputs. The bus-cycle engine downstream uses those outputs. Register reads inside the window return data combinationally in the same cycle.

Top module: `ide_cfgwin`

## Requirements
- R1: The window opens on the clock edge that ends this sequence: a 16-bit read at offset 1, another 16-bit read at offset 1 in the next access, then a byte (non-wide) write of 0x03 at offset 2. Further 16-bit reads at offset 1 keep the detector armed, because the last two reads count.
- R2: While the window is closed, any access that breaks the sequence returns the detector to idle, and the window stays closed. This includes a byte read at offset 1, another offset, or a wrong key byte. Idle cycles (no valid access) do not break the sequence.
- R3: While the window is open, a byte write of 0x83 at offset 2 closes it at that clock edge. Any other write at offset 2 has no effect.
- R4: `tf_route` equals `bus_valid` while the window is closed and is 0 while it is open. `cfg_rdata` is 0 whenever the window is closed or the access is not a read.
- R5: Inside the window, a write at offset 0 (read-cycle timing) or offset 1 (write-cycle timing) updates the staged byte of the device named by miscellaneous bit 0. A read at those offsets returns that device's staged byte.
- R6: Offset 6 is the miscellaneous register. It is fully writable and readable. Bit 0 selects the device, and bits 7:4 hold the address-setup field.
- R7: A read at offset 5 returns 0x01 when `strap_clk25` is 1 (25 MHz bus) and 0x00 when it is 0 (33 MHz bus). Writes at offset 5 change no register.
- R8: Offset 3 is the control register and is readable. Writing 0x85 there copies both devices' staged timings and the misc setup field to the committed outputs at that clock edge. Other values leave the committed outputs unchanged.
- R9: Reads at offsets 2, 4 and 7 inside the window return 0.
- R10: After reset the window is closed. All staged and committed timing bytes are 0xFF. Misc is 0xF0, the committed setup field is 0xF, and control is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | One access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_off | input | 3 | Offset from the base address |
| bus_wdata | input | 8 | Write data (low byte) |
| strap_clk25 | input | 1 | Bus clock strap, 1 = 25 MHz |
| tf_route | output | 1 | Access goes to the task file |
| cfg_rdata | output | 8 | Configuration read data |
| win_open | output | 1 | Configuration window open |
| tim_rd_o | output | 16 | Committed read timing, device n at [8n+7:8n] |
| tim_wr_o | output | 16 | Committed write timing, device n at [8n+7:8n] |
| setup_o | output | 4 | Committed shared address-setup field |

## Verification
The assertions check four things on every cycle. The window opens only right after a 0x03 key write and closes only right after a 0x83 key write. Routing and zero read data follow the window state. Committed outputs move only on the edge after a 0x85 control write. The strap and unmapped reads return fixed values. The bench scenarios cover the sequence-dependent behaviour: broken and extended unlock attempts, per-device steering of staged bytes through the select bit, and the values that the commit carries. A random mix of accesses, biased toward the key and commit codes, runs against a bench model of all registers.

// File: rtl/ide_cfgwin_pkg.sv
package ide_cfgwin_pkg;
    localparam int DW    = 8;
    localparam int OFF_W = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ONE  = 2'd1,
        SEQ_TWO  = 2'd2
    } seq_state_e;

    localparam logic [OFF_W-1:0] OFF_RDTIM = 3'd0;
    localparam logic [OFF_W-1:0] OFF_WRTIM = 3'd1;
    localparam logic [OFF_W-1:0] OFF_KEY   = 3'd2;
    localparam logic [OFF_W-1:0] OFF_CTRL  = 3'd3;
    localparam logic [OFF_W-1:0] OFF_STRAP = 3'd5;
    localparam logic [OFF_W-1:0] OFF_MISC  = 3'd6;
    localparam logic [OFF_W-1:0] OFF_PROBE = 3'd1;

    localparam logic [DW-1:0] KEY_OPEN   = 8'h03;
    localparam logic [DW-1:0] KEY_CLOSE  = 8'h83;
    localparam logic [DW-1:0] CMD_COMMIT = 8'h85;
endpackage

// File: rtl/ide_cfgwin_seq.sv
module ide_cfgwin_seq
    import ide_cfgwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic             acc_wide,
    input  logic [OFF_W-1:0] acc_off,
    input  logic [DW-1:0]    acc_wdata,
    output logic             open_o
);
    typedef struct packed {
        seq_state_e st;
        logic       open;
    } seq_s;

    seq_s s_d, s_q;
    logic probe_rd, open_key, close_key;

    always_comb begin
        probe_rd  = acc_valid && !acc_write && acc_wide && (acc_off == OFF_PROBE);
        open_key  = acc_valid && acc_write && !acc_wide && (acc_off == OFF_KEY)
                    && (acc_wdata == KEY_OPEN);
        close_key = acc_valid && acc_write && !acc_wide && (acc_off == OFF_KEY)
                    && (acc_wdata == KEY_CLOSE);
        s_d = s_q;
        if (s_q.open) begin
            s_d.st = SEQ_IDLE;
            if (close_key) s_d.open = 1'b0;
        end else if (acc_valid) begin
            if (probe_rd) begin
                s_d.st = (s_q.st == SEQ_IDLE) ? SEQ_ONE : SEQ_TWO;
            end else if ((s_q.st == SEQ_TWO) && open_key) begin
                s_d.st   = SEQ_IDLE;
                s_d.open = 1'b1;
            end else begin
                s_d.st = SEQ_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st   <= SEQ_IDLE;
            s_q.open <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign open_o = s_q.open;
endmodule

// File: rtl/ide_cfgwin_regs.sv
module ide_cfgwin_regs
    import ide_cfgwin_pkg::*;
#(
    parameter int NDEV      = 2,
    parameter int SETUP_W   = 4,
    parameter int SETUP_LSB = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [OFF_W-1:0]     wr_off,
    input  logic [DW-1:0]        wr_data,
    output logic [NDEV*DW-1:0]   stage_rd_o,
    output logic [NDEV*DW-1:0]   stage_wr_o,
    output logic [DW-1:0]        misc_o,
    output logic [DW-1:0]        ctrl_o,
    output logic [NDEV*DW-1:0]   com_rd_o,
    output logic [NDEV*DW-1:0]   com_wr_o,
    output logic [SETUP_W-1:0]   setup_o
);
    localparam int SEL_W = (NDEV > 1) ? $clog2(NDEV) : 1;
    localparam logic [DW-1:0] TIM_SLOW = '1;
    localparam logic [DW-1:0] MISC_RST = DW'({SETUP_W{1'b1}}) << SETUP_LSB;

    typedef struct packed {
        logic [NDEV-1:0][DW-1:0] stage_rd;
        logic [NDEV-1:0][DW-1:0] stage_wr;
        logic [NDEV-1:0][DW-1:0] com_rd;
        logic [NDEV-1:0][DW-1:0] com_wr;
        logic [DW-1:0]           misc;
        logic [DW-1:0]           ctrl;
        logic [SETUP_W-1:0]      setup;
    } reg_s;

    reg_s r_d, r_q;
    logic [SEL_W-1:0] dsel;
    logic             commit;

    always_comb begin
        dsel   = r_q.misc[SEL_W-1:0];
        commit = wr_en && (wr_off == OFF_CTRL) && (wr_data == CMD_COMMIT);
        r_d    = r_q;
        if (wr_en) begin
            case (wr_off)
                OFF_RDTIM: r_d.stage_rd[dsel] = wr_data;
                OFF_WRTIM: r_d.stage_wr[dsel] = wr_data;
                OFF_CTRL:  r_d.ctrl = wr_data;
                OFF_MISC:  r_d.misc = wr_data;
                default:   ;
            endcase
        end
        if (commit) begin
            for (int n = 0; n < NDEV; n++) begin
                r_d.com_rd[n] = r_q.stage_rd[n];
                r_d.com_wr[n] = r_q.stage_wr[n];
            end
            r_d.setup = r_q.misc[SETUP_LSB +: SETUP_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NDEV; n++) begin
                r_q.stage_rd[n] <= TIM_SLOW;
                r_q.stage_wr[n] <= TIM_SLOW;
                r_q.com_rd[n]   <= TIM_SLOW;
                r_q.com_wr[n]   <= TIM_SLOW;
            end
            r_q.misc  <= MISC_RST;
            r_q.ctrl  <= '0;
            r_q.setup <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar g = 0; g < NDEV; g++) begin : g_dev
        assign stage_rd_o[g*DW +: DW] = r_q.stage_rd[g];
        assign stage_wr_o[g*DW +: DW] = r_q.stage_wr[g];
        assign com_rd_o[g*DW +: DW]   = r_q.com_rd[g];
        assign com_wr_o[g*DW +: DW]   = r_q.com_wr[g];
    end

    assign misc_o  = r_q.misc;
    assign ctrl_o  = r_q.ctrl;
    assign setup_o = r_q.setup;
endmodule

// File: rtl/ide_cfgwin_rdmux.sv
module ide_cfgwin_rdmux
    import ide_cfgwin_pkg::*;
#(
    parameter int NDEV = 2
) (
    input  logic               rd_en,
    input  logic [OFF_W-1:0]   rd_off,
    input  logic [NDEV*DW-1:0] stage_rd,
    input  logic [NDEV*DW-1:0] stage_wr,
    input  logic [DW-1:0]      misc,
    input  logic [DW-1:0]      ctrl,
    input  logic               strap,
    output logic [DW-1:0]      rdata
);
    localparam int SEL_W = (NDEV > 1) ? $clog2(NDEV) : 1;
    logic [SEL_W-1:0] dsel;

    always_comb begin
        dsel  = misc[SEL_W-1:0];
        rdata = '0;
        if (rd_en) begin
            case (rd_off)
                OFF_RDTIM: rdata = stage_rd[dsel*DW +: DW];
                OFF_WRTIM: rdata = stage_wr[dsel*DW +: DW];
                OFF_CTRL:  rdata = ctrl;
                OFF_STRAP: rdata = {{(DW-1){1'b0}}, strap};
                OFF_MISC:  rdata = misc;
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ide_cfgwin.sv
module ide_cfgwin
    import ide_cfgwin_pkg::*;
#(
    parameter int NDEV      = 2,
    parameter int SETUP_W   = 4,
    parameter int SETUP_LSB = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic                 bus_wide,
    input  logic [OFF_W-1:0]     bus_off,
    input  logic [DW-1:0]        bus_wdata,
    input  logic                 strap_clk25,
    output logic                 tf_route,
    output logic [DW-1:0]        cfg_rdata,
    output logic                 win_open,
    output logic [NDEV*DW-1:0]   tim_rd_o,
    output logic [NDEV*DW-1:0]   tim_wr_o,
    output logic [SETUP_W-1:0]   setup_o
);
    logic [NDEV*DW-1:0] stage_rd, stage_wr;
    logic [DW-1:0]      misc, ctrl;
    logic               open;

    ide_cfgwin_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (bus_valid),
        .acc_write (bus_write),
        .acc_wide  (bus_wide),
        .acc_off   (bus_off),
        .acc_wdata (bus_wdata),
        .open_o    (open)
    );

    ide_cfgwin_regs #(
        .NDEV      (NDEV),
        .SETUP_W   (SETUP_W),
        .SETUP_LSB (SETUP_LSB)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_valid && bus_write && open),
        .wr_off     (bus_off),
        .wr_data    (bus_wdata),
        .stage_rd_o (stage_rd),
        .stage_wr_o (stage_wr),
        .misc_o     (misc),
        .ctrl_o     (ctrl),
        .com_rd_o   (tim_rd_o),
        .com_wr_o   (tim_wr_o),
        .setup_o    (setup_o)
    );

    ide_cfgwin_rdmux #(.NDEV(NDEV)) u_rdmux (
        .rd_en    (bus_valid && !bus_write && open),
        .rd_off   (bus_off),
        .stage_rd (stage_rd),
        .stage_wr (stage_wr),
        .misc     (misc),
        .ctrl     (ctrl),
        .strap    (strap_clk25),
        .rdata    (cfg_rdata)
    );

    assign tf_route = bus_valid && !open;
    assign win_open = open;
endmodule

// File: rtl/ide_cfgwin_chk.sv
module ide_cfgwin_chk
    import ide_cfgwin_pkg::*;
#(
    parameter int NDEV    = 2,
    parameter int SETUP_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic                 bus_wide,
    input logic [OFF_W-1:0]     bus_off,
    input logic [DW-1:0]        bus_wdata,
    input logic                 strap_clk25,
    input logic                 tf_route,
    input logic [DW-1:0]        cfg_rdata,
    input logic                 win_open,
    input logic [NDEV*DW-1:0]   tim_rd_o,
    input logic [NDEV*DW-1:0]   tim_wr_o,
    input logic [SETUP_W-1:0]   setup_o
);
    logic key_wr, commit_wr, cfg_rd;
    assign key_wr    = bus_valid && bus_write && !bus_wide && (bus_off == OFF_KEY);
    assign commit_wr = bus_valid && bus_write && win_open && (bus_off == OFF_CTRL)
                       && (bus_wdata == CMD_COMMIT);
    assign cfg_rd    = bus_valid && !bus_write && win_open;

    a_r1_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> $past(key_wr && bus_wdata == KEY_OPEN));

    a_r3_close_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(win_open) |-> $past(key_wr && bus_wdata == KEY_CLOSE));

    a_r4_route_follows_window: assert property (@(posedge clk) disable iff (!rst_n)
        tf_route == (bus_valid && !win_open));

    a_r4_rdata_zero_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd |-> cfg_rdata == '0);

    a_r7_strap_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && bus_off == OFF_STRAP) |-> cfg_rdata == {{(DW-1){1'b0}}, strap_clk25});

    a_r8_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(commit_wr) |-> ($stable(tim_rd_o) && $stable(tim_wr_o) && $stable(setup_o)));

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && (bus_off == 3'd2 || bus_off == 3'd4 || bus_off == 3'd7))
        |-> cfg_rdata == '0);
endmodule

bind ide_cfgwin ide_cfgwin_chk #(.NDEV(NDEV), .SETUP_W(SETUP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_wide    (bus_wide),
    .bus_off     (bus_off),
    .bus_wdata   (bus_wdata),
    .strap_clk25 (strap_clk25),
    .tf_route    (tf_route),
    .cfg_rdata   (cfg_rdata),
    .win_open    (win_open),
    .tim_rd_o    (tim_rd_o),
    .tim_wr_o    (tim_wr_o),
    .setup_o     (setup_o)
);

// File: tb/ide_cfgwin_tb.sv
module ide_cfgwin_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_valid = 1'b0, bus_write = 1'b0, bus_wide = 1'b0;
    logic [2:0] bus_off = '0;
    logic [7:0] bus_wdata = '0;
    logic       strap_clk25 = 1'b0;
    logic       tf_route, win_open;
    logic [7:0] cfg_rdata;
    logic [15:0] tim_rd_o, tim_wr_o;
    logic [3:0]  setup_o;

    int nchk = 0;
    int nfail = 0;

    // bench model of the register state
    bit       m_open;
    int       m_seq;
    bit [7:0] m_srd [2];
    bit [7:0] m_swr [2];
    bit [7:0] m_crd [2];
    bit [7:0] m_cwr [2];
    bit [7:0] m_misc, m_ctrl;
    bit [3:0] m_setup;

    always #4 clk = ~clk;

    ide_cfgwin u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_wide(bus_wide), .bus_off(bus_off), .bus_wdata(bus_wdata),
        .strap_clk25(strap_clk25), .tf_route(tf_route), .cfg_rdata(cfg_rdata),
        .win_open(win_open), .tim_rd_o(tim_rd_o), .tim_wr_o(tim_wr_o), .setup_o(setup_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] exp_rdata(bit wr, bit [2:0] off, bit strap);
        if (!m_open || wr) return 8'h00;
        case (off)
            3'd0: return m_srd[m_misc[0]];
            3'd1: return m_swr[m_misc[0]];
            3'd3: return m_ctrl;
            3'd5: return {7'b0, strap};
            3'd6: return m_misc;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_open = 0; m_seq = 0;
        for (int n = 0; n < 2; n++) begin
            m_srd[n] = 8'hFF; m_swr[n] = 8'hFF; m_crd[n] = 8'hFF; m_cwr[n] = 8'hFF;
        end
        m_misc = 8'hF0; m_ctrl = 8'h00; m_setup = 4'hF;
    endtask

    task automatic model_step(bit wr, bit wide, bit [2:0] off, bit [7:0] d);
        if (!m_open) begin
            if (!wr && wide && off == 3'd1) m_seq = (m_seq == 0) ? 1 : 2;
            else if (m_seq == 2 && wr && !wide && off == 3'd2 && d == 8'h03) begin
                m_open = 1; m_seq = 0;
            end else m_seq = 0;
        end else if (wr) begin
            case (off)
                3'd0: m_srd[m_misc[0]] = d;
                3'd1: m_swr[m_misc[0]] = d;
                3'd2: if (!wide && d == 8'h83) m_open = 0;
                3'd3: begin
                    if (d == 8'h85) begin
                        m_crd[0] = m_srd[0]; m_crd[1] = m_srd[1];
                        m_cwr[0] = m_swr[0]; m_cwr[1] = m_swr[1];
                        m_setup  = m_misc[7:4];
                    end
                    m_ctrl = d;
                end
                3'd6: m_misc = d;
                default: ;
            endcase
        end
    endtask

    // registered outputs, sampled mid-cycle
    task automatic check_state(string req);
        chk({req, " win_open"}, win_open, m_open);
        chk({req, " tim_rd"}, tim_rd_o, {m_crd[1], m_crd[0]});
        chk({req, " tim_wr"}, tim_wr_o, {m_cwr[1], m_cwr[0]});
        chk({req, " setup"}, setup_o, m_setup);
    endtask

    task automatic acc(string req, bit wr, bit wide, bit [2:0] off, bit [7:0] d);
        @(negedge clk);
        check_state(req);
        bus_valid = 1; bus_write = wr; bus_wide = wide; bus_off = off; bus_wdata = d;
        #1;
        chk({req, " R4 tf_route"}, tf_route, !m_open);
        chk({req, " rdata"}, cfg_rdata, exp_rdata(wr, off, strap_clk25));
        @(posedge clk);
        model_step(wr, wide, off, d);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_valid = 0;
        #1;
        chk("R4 idle tf_route", tf_route, 1'b0);
        @(posedge clk);
    endtask

    task automatic unlock();
        acc("R1 probe", 0, 1, 3'd1, 8'h00);
        acc("R1 probe", 0, 1, 3'd1, 8'h00);
        acc("R1 key", 1, 0, 3'd2, 8'h03);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual expired expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        bit [7:0] kv;
        model_reset();
        void'($urandom(32'h5EED_1DE0));
        repeat (3) @(posedge clk);
        rst_n = 1;
        // R10 reset state
        @(negedge clk);
        check_state("R10 reset");
        // R2: broken sequences stay locked
        acc("R2 probe", 0, 1, 3'd1, 0);
        acc("R2 byte read breaks", 0, 0, 3'd1, 0);
        acc("R2 probe", 0, 1, 3'd1, 0);
        acc("R2 key early", 1, 0, 3'd2, 8'h03);
        acc("R2 probe", 0, 1, 3'd1, 0);
        acc("R2 probe", 0, 1, 3'd1, 0);
        acc("R2 bad key", 1, 0, 3'd2, 8'h13);
        acc("R2 late key", 1, 0, 3'd2, 8'h03);
        acc("R2 check", 0, 0, 3'd0, 0);
        chk("R2 still locked", win_open, 1'b0);
        // R1: three reads, idle gap, key opens
        acc("R1 probe", 0, 1, 3'd1, 0);
        idle();
        acc("R1 probe", 0, 1, 3'd1, 0);
        acc("R1 probe", 0, 1, 3'd1, 0);
        acc("R1 key", 1, 0, 3'd2, 8'h03);
        acc("R1 opened", 0, 0, 3'd6, 0);
        chk("R1 open", win_open, 1'b1);
        // R10 reset register values readable, R9 unmapped
        acc("R10 misc", 0, 0, 3'd6, 0);
        acc("R10 ctrl", 0, 0, 3'd3, 0);
        acc("R10 stage", 0, 0, 3'd0, 0);
        acc("R9 off2", 0, 0, 3'd2, 0);
        acc("R9 off4", 0, 0, 3'd4, 0);
        acc("R9 off7", 0, 1, 3'd7, 0);
        // R7 strap reads and ignored writes
        strap_clk25 = 1;
        acc("R7 strap 25", 0, 0, 3'd5, 0);
        acc("R7 strap write", 1, 0, 3'd5, 8'hA5);
        acc("R7 after write", 0, 0, 3'd5, 0);
        strap_clk25 = 0;
        acc("R7 strap 33", 0, 0, 3'd5, 0);
        // R5/R6 per-device staging
        acc("R6 sel dev0", 1, 0, 3'd6, 8'h20);
        acc("R5 dev0 rd", 1, 0, 3'd0, 8'h59);
        acc("R5 dev0 wr", 1, 0, 3'd1, 8'h46);
        acc("R6 sel dev1", 1, 0, 3'd6, 8'h31);
        acc("R5 dev1 rd", 1, 0, 3'd0, 8'h20);
        acc("R5 dev1 wr", 1, 0, 3'd1, 8'h10);
        acc("R5 dev1 readback", 0, 0, 3'd0, 0);
        acc("R6 misc readback", 0, 0, 3'd6, 0);
        acc("R6 sel dev0 again", 1, 0, 3'd6, 8'h30);
        acc("R5 dev0 readback", 0, 0, 3'd1, 0);
        // R8 non-commit value, then commit
        acc("R8 other ctrl", 1, 0, 3'd3, 8'h05);
        acc("R8 ctrl readback", 0, 0, 3'd3, 0);
        acc("R8 commit", 1, 0, 3'd3, 8'h85);
        acc("R8 after commit", 0, 0, 3'd3, 0);
        chk("R8 dev1 rd timing", tim_rd_o[15:8], 8'h20);
        chk("R8 setup", setup_o, 4'h3);
        // R3 wrong key ignored, then close
        acc("R3 wrong key", 1, 0, 3'd2, 8'h03);
        acc("R3 wide close ignored", 1, 1, 3'd2, 8'h83);
        acc("R3 close", 1, 0, 3'd2, 8'h83);
        acc("R3 closed", 0, 0, 3'd6, 0);
        chk("R3 closed", win_open, 1'b0);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            int k;
            k = int'($urandom % 16);
            strap_clk25 = 1'($urandom);
            if (k == 0) unlock();
            else if (k == 1) idle();
            else begin
                case ($urandom % 4)
                    0: kv = 8'h03;
                    1: kv = 8'h83;
                    2: kv = 8'h85;
                    default: kv = 8'($urandom);
                endcase
                acc("R5 random", 1'($urandom), 1'($urandom), 3'($urandom), kv);
            end
        end
        @(negedge clk);
        check_state("R8 final");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule